// File: doc/BRIEF.md
# Transceiver FIFO interrupt request controller

This block drives the single active-high interrupt line that a packet transceiver presents to its host microcontroller. It watches six event sources (power status changes, TX buffer fill level, RX buffer fill level, receive errors, a successful bit-check, and TX buffer empty in full-duplex operation), catches each one on its rising edge into a sticky pending bit, and raises the line while any pending bit is set. The host reads the pending vector to tell the sources apart.

Each source is cleared only by the host operations that belong to it. A status-register read clears only the status event, so a line that stays high after that read points the host at a buffer source. The TX-side and RX-side buffer events are also cleared by a write to a chosen subset of control registers or by the delete-interrupt command. While the host is reading a buffer, received-byte and receive-error events cannot set their pending bits. If an event and a clear for the same source land in the same cycle, the event is kept.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `irq` is 0 and `src` is all zeros. Levels that are already present when reset is released are not taken as new events.
- R2: In any mode, a change of `pwr_low` in either direction, or a rise of `pwr_on`, sets `src[0]`. Only `status_rd` or `irq_del` clears it.
- R3: In TX mode (`mode`=01), `src[1]` is set when `tx_level` becomes equal to the threshold picked by `thr_sel` (00: 1 byte, 01: 2, 10: 4, 11: 12).
- R4: In TX mode, `tx_level` becoming 0 also sets `src[1]`, whatever `thr_sel` is.
- R5: `src[1]` is cleared by `txbuf_wr`, by `irq_del`, or by `ctrl_wr` when `ctrl_addr` is 1, 4, 5, 6 or 7. A control write to address 0, 2 or 3 has no effect on it.
- R6: In RX mode (`mode`=10), `rx_level` reaching the `thr_sel` threshold sets `src[2]`, and an `rx_error` pulse sets `src[3]`.
- R7: `src[2]`, `src[3]` and `src[4]` are cleared by `rxbuf_rd`, by `irq_del`, or by a control write to address 1, 4, 5, 6 or 7.
- R8: In RX mode, a `bchk_ok` pulse sets `src[4]` only when `bchk_mode` is 0. When `bchk_mode` is 1 the pulse is ignored.
- R9: In full-duplex mode (`mode`=11), `tx_level` becoming 0 sets `src[5]`. It clears under the same operations as R5.
- R10: While `host_buf_busy` is 1, neither the RX threshold nor `rx_error` sets a pending bit. An edge that arrives during that time is lost.
- R11: A `status_rd` leaves every buffer pending bit, and therefore `irq`, unchanged.
- R12: When a set and a clear of the same source fall in the same cycle, the bit ends up set.
- R13: A condition that stays true does not set its bit again after that bit is cleared. Only a new rising edge sets it.
- R14: In idle mode (`mode`=00), no buffer source sets a pending bit. `irq` is 1 exactly when any `src` bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Operating mode: 00 idle, 01 TX, 10 RX, 11 full duplex |
| thr_sel | input | 2 | Fill threshold select (1, 2, 4, 12 bytes) |
| tx_level | input | LVL_W | TX buffer fill level in bytes |
| rx_level | input | LVL_W | RX buffer fill level in bytes |
| rx_error | input | 1 | Receive error pulse |
| bchk_ok | input | 1 | Successful bit-check pulse |
| bchk_mode | input | 1 | Bit-check mode flag; 1 masks bit-check events |
| pwr_low | input | 1 | Power-low status level |
| pwr_on | input | 1 | Power-on status level |
| status_rd | input | 1 | Host status-register read strobe |
| rxbuf_rd | input | 1 | Host RX buffer read strobe |
| txbuf_wr | input | 1 | Host TX buffer write strobe |
| ctrl_wr | input | 1 | Host control-register write strobe |
| ctrl_addr | input | CTRL_AW | Control register index of the write |
| irq_del | input | 1 | Delete-interrupt command strobe |
| host_buf_busy | input | 1 | Host buffer read in progress |
| irq | output | 1 | Interrupt request line, active high |
| src | output | 6 | Pending vector: 0 status, 1 TX level, 2 RX level, 3 RX error, 4 bit-check, 5 duplex TX empty |

## Verification
On every cycle, the checker enforces the per-source rules. A status read never drops a pending TX bit and does clear the status bit when no new power event arrives. Idle mode, a busy host buffer and a set bit-check mode flag each keep their sources from setting. A receive error paired with a clear in the same cycle stays pending, and a delete command with no error pulse clears the error bit. Some behaviour can only be shown by the bench's scenarios, because it depends on event histories. These cover each threshold value, TX empty occurring while the threshold condition is still true, edges lost while the buffer is busy, conditions that stay true and do not set their bit again, and control writes to addresses outside the clearing set.

// File: rtl/irq_ctrl_pkg.sv
// Shared definitions for the transceiver interrupt controller: mode
// encoding, pending-vector bit positions, clear groups and the threshold
// decode. Assumes a 2-bit threshold select.
package irq_ctrl_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_TX   = 2'b01,
        MODE_RX   = 2'b10,
        MODE_FDX  = 2'b11
    } op_mode_e;

    localparam int NSRC      = 6;
    localparam int SRC_STAT  = 0;
    localparam int SRC_TXLVL = 1;
    localparam int SRC_RXLVL = 2;
    localparam int SRC_RXERR = 3;
    localparam int SRC_BCHK  = 4;
    localparam int SRC_FDXE  = 5;

    typedef enum logic [1:0] {
        GRP_STATUS = 2'd0,
        GRP_TXSIDE = 2'd1,
        GRP_RXSIDE = 2'd2
    } clr_grp_e;

    // Which family of host operations clears a given source.
    function automatic clr_grp_e src_group(input int idx);
        case (idx)
            SRC_STAT:            return GRP_STATUS;
            SRC_TXLVL, SRC_FDXE: return GRP_TXSIDE;
            default:             return GRP_RXSIDE;
        endcase
    endfunction

    // Byte count selected by the threshold field.
    function automatic int unsigned thr_bytes(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/irq_src_detect.sv
// Event detection. Forms the level conditions of every source, gated by
// the mode, and turns them into one-cycle set requests on their rising
// edges. The history register loads the live level even during reset, so
// a level already present at reset release is not taken as an event.
// Assumes LVL_W is wide enough to hold the largest threshold (12).
module irq_src_detect
    import irq_ctrl_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic [1:0]       mode,
    input  logic [1:0]       thr_sel,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_error,
    input  logic             bchk_ok,
    input  logic             bchk_mode,
    input  logic             pwr_low,
    input  logic             pwr_on,
    input  logic             host_buf_busy,
    output logic [NSRC-1:0]  set_vec
);

    localparam int NLVL  = 6;
    localparam int L_TXT = 0;  // TX threshold match, TX mode
    localparam int L_TXE = 1;  // TX empty, TX mode
    localparam int L_RXT = 2;  // RX threshold match, RX mode
    localparam int L_FDE = 3;  // TX empty, full duplex mode
    localparam int L_PON = 4;  // power-on level
    localparam int L_PLO = 5;  // power-low level

    op_mode_e           mode_e;
    logic [LVL_W-1:0]   thr_lvl;
    logic [NLVL-1:0]    lvl_now;
    logic [NLVL-1:0]    lvl_q;
    logic [NLVL-1:0]    lvl_rise;

    assign mode_e  = op_mode_e'(mode);
    assign thr_lvl = LVL_W'(thr_bytes(thr_sel));

    // Level conditions of every edge-captured source.
    always_comb begin
        lvl_now        = '0;
        lvl_now[L_TXT] = (mode_e == MODE_TX)  && (tx_level == thr_lvl);
        lvl_now[L_TXE] = (mode_e == MODE_TX)  && (tx_level == '0);
        lvl_now[L_RXT] = (mode_e == MODE_RX)  && (rx_level == thr_lvl);
        lvl_now[L_FDE] = (mode_e == MODE_FDX) && (tx_level == '0);
        lvl_now[L_PON] = pwr_on;
        lvl_now[L_PLO] = pwr_low;
    end

    // History of the level conditions, loaded on every edge.
    always_ff @(posedge clk) begin
        lvl_q <= lvl_now;
    end

    assign lvl_rise = lvl_now & ~lvl_q;

    // Map edges and pulses onto per-source set requests.
    always_comb begin
        set_vec            = '0;
        set_vec[SRC_STAT]  = lvl_rise[L_PON] | (lvl_now[L_PLO] ^ lvl_q[L_PLO]);
        set_vec[SRC_TXLVL] = lvl_rise[L_TXT] | lvl_rise[L_TXE];
        set_vec[SRC_RXLVL] = lvl_rise[L_RXT] & ~host_buf_busy;
        set_vec[SRC_RXERR] = (mode_e == MODE_RX) & rx_error & ~host_buf_busy;
        set_vec[SRC_BCHK]  = (mode_e == MODE_RX) & bchk_ok & ~bchk_mode;
        set_vec[SRC_FDXE]  = lvl_rise[L_FDE];
    end

endmodule

// File: rtl/irq_clr_decode.sv
// Clear decode. Turns the host access strobes into a per-source clear
// vector. Each source belongs to one clear group. CTRL_CLR_MASK marks the
// control register indices whose write clears buffer sources.
module irq_clr_decode
    import irq_ctrl_pkg::*;
#(
    parameter int                   CTRL_AW       = 3,
    parameter logic [2**CTRL_AW-1:0] CTRL_CLR_MASK = 8'b1111_0010
) (
    input  logic               status_rd,
    input  logic               rxbuf_rd,
    input  logic               txbuf_wr,
    input  logic               ctrl_wr,
    input  logic [CTRL_AW-1:0] ctrl_addr,
    input  logic               irq_del,
    output logic [NSRC-1:0]    clr_vec
);

    logic ctrl_hit;
    logic clr_status;
    logic clr_txside;
    logic clr_rxside;

    // Group-level clear terms.
    always_comb begin
        ctrl_hit   = ctrl_wr & CTRL_CLR_MASK[ctrl_addr];
        clr_status = status_rd | irq_del;
        clr_txside = txbuf_wr | ctrl_hit | irq_del;
        clr_rxside = rxbuf_rd | ctrl_hit | irq_del;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_clr
        localparam clr_grp_e GRP = src_group(i);
        if (GRP == GRP_STATUS) begin : g_stat
            assign clr_vec[i] = clr_status;
        end else if (GRP == GRP_TXSIDE) begin : g_tx
            assign clr_vec[i] = clr_txside;
        end else begin : g_rx
            assign clr_vec[i] = clr_rxside;
        end
    end

endmodule

// File: rtl/irq_pend_bank.sv
// Sticky pending bits, one per source. A set request wins over a clear in
// the same cycle so that no event is lost.
module irq_pend_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold the bit, set it on request, drop it on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else begin
                pend[i] <= set_vec[i] | (pend[i] & ~clr_vec[i]);
            end
        end
    end

endmodule

// File: rtl/fifo_irq_ctrl.sv
// Top of the transceiver interrupt controller. Event detection feeds set
// requests, host strobes feed clear requests, and a sticky bank holds the
// pending vector. The IRQ line is the OR of the bank.
// Assumes single-cycle host strobes and synchronous inputs.
module fifo_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int                    LVL_W         = 5,
    parameter int                    CTRL_AW       = 3,
    parameter logic [2**CTRL_AW-1:0] CTRL_CLR_MASK = 8'b1111_0010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode,
    input  logic [1:0]         thr_sel,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic               rx_error,
    input  logic               bchk_ok,
    input  logic               bchk_mode,
    input  logic               pwr_low,
    input  logic               pwr_on,
    input  logic               status_rd,
    input  logic               rxbuf_rd,
    input  logic               txbuf_wr,
    input  logic               ctrl_wr,
    input  logic [CTRL_AW-1:0] ctrl_addr,
    input  logic               irq_del,
    input  logic               host_buf_busy,
    output logic               irq,
    output logic [NSRC-1:0]    src
);

    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] pend;

    irq_src_detect #(.LVL_W(LVL_W)) u_detect (
        .clk           (clk),
        .mode          (mode),
        .thr_sel       (thr_sel),
        .tx_level      (tx_level),
        .rx_level      (rx_level),
        .rx_error      (rx_error),
        .bchk_ok       (bchk_ok),
        .bchk_mode     (bchk_mode),
        .pwr_low       (pwr_low),
        .pwr_on        (pwr_on),
        .host_buf_busy (host_buf_busy),
        .set_vec       (set_vec)
    );

    irq_clr_decode #(.CTRL_AW(CTRL_AW), .CTRL_CLR_MASK(CTRL_CLR_MASK)) u_clr (
        .status_rd (status_rd),
        .rxbuf_rd  (rxbuf_rd),
        .txbuf_wr  (txbuf_wr),
        .ctrl_wr   (ctrl_wr),
        .ctrl_addr (ctrl_addr),
        .irq_del   (irq_del),
        .clr_vec   (clr_vec)
    );

    irq_pend_bank #(.N(NSRC)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend)
    );

    // Drive the line and the source indication from the bank.
    always_comb begin
        src = pend;
        irq = |pend;
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
// Property checker for fifo_irq_ctrl, attached through bind. It relates
// the host strobes and event inputs to the pending vector one cycle later.
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mode,
    input logic            rx_error,
    input logic            bchk_mode,
    input logic            pwr_low,
    input logic            pwr_on,
    input logic            status_rd,
    input logic            rxbuf_rd,
    input logic            txbuf_wr,
    input logic            ctrl_wr,
    input logic            irq_del,
    input logic            host_buf_busy,
    input logic [NSRC-1:0] src
);

    // R11
    stat_rd_keeps_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !irq_del && !txbuf_wr && !ctrl_wr && src[SRC_TXLVL]) |=> src[SRC_TXLVL]);

    // R2
    stat_rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && $stable(pwr_low) && !$rose(pwr_on)) |=> !src[SRC_STAT]);

    // R14
    idle_tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE && !src[SRC_TXLVL]) |=> !src[SRC_TXLVL]);

    // R14
    idle_rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE && !src[SRC_RXLVL]) |=> !src[SRC_RXLVL]);

    // R10
    busy_err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_buf_busy && !src[SRC_RXERR]) |=> !src[SRC_RXERR]);

    // R10
    busy_lvl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_buf_busy && !src[SRC_RXLVL]) |=> !src[SRC_RXLVL]);

    // R8
    bchk_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bchk_mode && !src[SRC_BCHK]) |=> !src[SRC_BCHK]);

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RX && rx_error && !host_buf_busy && (rxbuf_rd || irq_del)) |=> src[SRC_RXERR]);

    // R7
    del_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_del && !rx_error) |=> !src[SRC_RXERR]);

endmodule

bind fifo_irq_ctrl irq_ctrl_chk u_irq_ctrl_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode),
    .rx_error      (rx_error),
    .bchk_mode     (bchk_mode),
    .pwr_low       (pwr_low),
    .pwr_on        (pwr_on),
    .status_rd     (status_rd),
    .rxbuf_rd      (rxbuf_rd),
    .txbuf_wr      (txbuf_wr),
    .ctrl_wr       (ctrl_wr),
    .irq_del       (irq_del),
    .host_buf_busy (host_buf_busy),
    .src           (src)
);

// File: tb/test_fifo_irq_ctrl.sv
module test_fifo_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = '0;
    logic [1:0] thr_sel = '0;
    logic [4:0] tx_level = '0;
    logic [4:0] rx_level = '0;
    logic       rx_error = 1'b0, bchk_ok = 1'b0, bchk_mode = 1'b0;
    logic       pwr_low = 1'b0, pwr_on = 1'b0;
    logic       status_rd = 1'b0, rxbuf_rd = 1'b0, txbuf_wr = 1'b0, ctrl_wr = 1'b0;
    logic [2:0] ctrl_addr = '0;
    logic       irq_del = 1'b0, host_buf_busy = 1'b0;
    logic       irq;
    logic [5:0] src;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fifo_irq_ctrl i_fifo_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .thr_sel(thr_sel),
        .tx_level(tx_level), .rx_level(rx_level), .rx_error(rx_error),
        .bchk_ok(bchk_ok), .bchk_mode(bchk_mode), .pwr_low(pwr_low),
        .pwr_on(pwr_on), .status_rd(status_rd), .rxbuf_rd(rxbuf_rd),
        .txbuf_wr(txbuf_wr), .ctrl_wr(ctrl_wr), .ctrl_addr(ctrl_addr),
        .irq_del(irq_del), .host_buf_busy(host_buf_busy), .irq(irq), .src(src)
    );

    typedef struct packed {
        logic [1:0] m;
        logic [1:0] thr;
        logic [4:0] txl;
        logic [4:0] rxl;
        logic       err, bok, bm, pl, pon, srd, rrd, twr, cwr;
        logic [2:0] cad;
        logic       del, busy;
        logic [5:0] ex;
    } vec_t;

    localparam int NV = 48;
    // m thr txl rxl | err bok bm pl pon | srd rrd twr cwr cad del busy | expected src
    localparam vec_t VEC [0:NV-1] = '{
        '{2'd0,2'd0,5'd3,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 0  R14
        '{2'd0,2'd0,5'd3,5'd0, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h01}, // 1  R2
        '{2'd0,2'd0,5'd3,5'd0, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 2  R2
        '{2'd0,2'd0,5'd3,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h01}, // 3  R2
        '{2'd0,2'd0,5'd3,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0, 6'h00}, // 4  R2
        '{2'd0,2'd0,5'd3,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h01}, // 5  R2
        '{2'd0,2'd0,5'd3,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 6  R2
        '{2'd1,2'd0,5'd3,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 7  R3
        '{2'd1,2'd0,5'd1,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h02}, // 8  R3
        '{2'd1,2'd0,5'd1,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h02}, // 9  R11
        '{2'd1,2'd0,5'd1,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 10 R5 R13
        '{2'd1,2'd1,5'd3,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 11 R3
        '{2'd1,2'd1,5'd2,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h02}, // 12 R3
        '{2'd1,2'd1,5'd2,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,3'd2,1'b0,1'b0, 6'h02}, // 13 R5
        '{2'd1,2'd1,5'd2,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,3'd4,1'b0,1'b0, 6'h00}, // 14 R5
        '{2'd1,2'd2,5'd3,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 15 R3
        '{2'd1,2'd2,5'd4,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h02}, // 16 R3
        '{2'd1,2'd2,5'd4,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,3'd0,1'b0,1'b0, 6'h02}, // 17 R5
        '{2'd1,2'd2,5'd4,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0, 6'h00}, // 18 R5
        '{2'd1,2'd3,5'd11,5'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 19 R3
        '{2'd1,2'd3,5'd12,5'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h02}, // 20 R3
        '{2'd1,2'd3,5'd12,5'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,3'd7,1'b0,1'b0, 6'h00}, // 21 R5
        '{2'd1,2'd3,5'd0,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h02}, // 22 R4
        '{2'd1,2'd3,5'd0,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 23 R5
        '{2'd2,2'd0,5'd0,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 24 R6
        '{2'd2,2'd0,5'd0,5'd1, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h04}, // 25 R6
        '{2'd2,2'd0,5'd0,5'd1, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h04}, // 26 R11
        '{2'd2,2'd0,5'd0,5'd1, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 27 R7
        '{2'd2,2'd0,5'd0,5'd0, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h08}, // 28 R6
        '{2'd2,2'd0,5'd0,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,3'd5,1'b0,1'b0, 6'h00}, // 29 R7
        '{2'd2,2'd0,5'd0,5'd0, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b1, 6'h00}, // 30 R10
        '{2'd2,2'd0,5'd0,5'd1, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b1, 6'h00}, // 31 R10
        '{2'd2,2'd0,5'd0,5'd0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 32 R10
        '{2'd2,2'd1,5'd0,5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h04}, // 33 R6
        '{2'd2,2'd1,5'd0,5'd2, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h08}, // 34 R12
        '{2'd2,2'd1,5'd0,5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0, 6'h00}, // 35 R7 R13
        '{2'd2,2'd1,5'd0,5'd2, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h10}, // 36 R8
        '{2'd2,2'd1,5'd0,5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 37 R8
        '{2'd2,2'd1,5'd0,5'd2, 1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 38 R8
        '{2'd2,2'd1,5'd0,5'd2, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,3'd6,1'b0,1'b0, 6'h10}, // 39 R12
        '{2'd2,2'd1,5'd0,5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0, 6'h00}, // 40 R7
        '{2'd3,2'd1,5'd0,5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h20}, // 41 R9
        '{2'd3,2'd1,5'd0,5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h20}, // 42 R11
        '{2'd3,2'd1,5'd0,5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 43 R9
        '{2'd3,2'd1,5'd2,5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}, // 44 R9
        '{2'd3,2'd1,5'd0,5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h20}, // 45 R9
        '{2'd3,2'd1,5'd0,5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0, 6'h00}, // 46 R9
        '{2'd0,2'd1,5'd0,5'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 6'h00}  // 47 R14
    };

    task automatic drive(input vec_t v);
        mode = v.m; thr_sel = v.thr; tx_level = v.txl; rx_level = v.rxl;
        rx_error = v.err; bchk_ok = v.bok; bchk_mode = v.bm;
        pwr_low = v.pl; pwr_on = v.pon; status_rd = v.srd; rxbuf_rd = v.rrd;
        txbuf_wr = v.twr; ctrl_wr = v.cwr; ctrl_addr = v.cad;
        irq_del = v.del; host_buf_busy = v.busy;
    endtask

    task automatic check(input string req, input logic [5:0] exp_src);
        total++;
        if (src !== exp_src || irq !== (exp_src != 6'h00)) begin
            bad++;
            $display("FAIL %s: irq=%b src=%h expected irq=%b src=%h",
                     req, irq, src, (exp_src != 6'h00), exp_src);
        end
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        #500us;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state with inputs idle
        repeat (3) @(negedge clk);
        check("R1 in reset", 6'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 6'h00);

        // Vector walk over R2..R14
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check($sformatf("vector %0d", i), VEC[i].ex);
        end

        // R1 R13: pending bit dropped by reset; held level not re-captured
        drive('0);
        @(negedge clk);
        mode = 2'd1; tx_level = 5'd0;
        @(negedge clk);
        check("R4 empty before reset", 6'h02);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 mid-run reset", 6'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 R13 held level after release", 6'h00);
        @(negedge clk);
        check("R13 held level stays quiet", 6'h00);

        // R2 R11: status plus buffer pending; status read keeps irq high
        pwr_on = 1'b1; tx_level = 5'd5;
        @(negedge clk);
        check("R2 power-on rise", 6'h01);
        tx_level = 5'd0;
        @(negedge clk);
        check("R4 empty with status pending", 6'h03);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        check("R11 status read leaves TX bit", 6'h02);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule